// File: doc/BRIEF.md
# Outstanding Request Watchdog Timer

This block guards a stream of high-priority requests against stalls. Each request raises `enq_i` for one cycle when it enters a send queue and `deq_i` for one cycle when it completes or is flushed. The block counts the requests still in flight and runs a down-counting timer while at least one of them is pending. If the timer runs out while the count is still nonzero, the block emits a one-cycle `cancel_o` pulse. The surrounding logic uses that pulse to abort pending sends and to tear down a blocked head of line.

The timer starts only when the count goes from zero to one. Any dequeue that leaves requests pending while the timer runs reloads it with a full interval. The dequeue that empties the count stops it. The interval comes from `interval_i` in clock cycles. A value of zero selects a default that the parameters derive from a 50 ms period at the stated clock rate. A dequeue with nothing outstanding is dropped and sets a sticky flag. A synchronous clear returns the block to its reset state.

Top module: `pending_watchdog`

## Requirements
- R1: An enqueue without a dequeue raises `count_o` by one on the next cycle. At the maximum value (2^CNT_W-1) the enqueue is ignored and the count holds.
- R2: An enqueue without a dequeue at count zero arms the timer, so `running_o` is high on the next cycle. The load value is `interval_i`, or the default (CLK_HZ/1000 × PERIOD_MS cycles) when `interval_i` is zero. Further enqueues do not reload the timer.
- R3: While the timer runs, a dequeue that leaves the count nonzero reloads it with a full interval.
- R4: A dequeue that takes the count from one to zero stops the timer on the next cycle, and no cancel follows.
- R5: When the timer runs out, `cancel_o` is high for exactly one cycle. It rises on the Nth clock edge after the edge that loaded the value N, `running_o` drops on that same edge, and `count_o` is unchanged.
- R6: After a cancel the timer stays stopped. Later enqueues and dequeues do not restart it until the count has reached zero and a new zero-to-one enqueue occurs.
- R7: An enqueue and a dequeue in the same cycle leave the count unchanged. They reload the timer when the count is nonzero and the timer runs, and they have no effect at count zero.
- R8: A dequeue alone at count zero leaves the count at zero and sets `underflow_o`. The flag stays high until reset or clear.
- R9: `clr_i` has priority over all other inputs. On the next cycle the count is zero, the timer is stopped, and `underflow_o` and `cancel_o` are low.
- R10: After reset all outputs are zero.
- R11: `cancel_o` is never high in two consecutive cycles, and it is high only while `count_o` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_i | input | 1 | One-cycle pulse: a request entered the queue |
| deq_i | input | 1 | One-cycle pulse: a request completed or was flushed |
| clr_i | input | 1 | Synchronous clear to the reset state |
| interval_i | input | TMR_W | Timeout in clock cycles; zero selects the default |
| count_o | output | CNT_W | Requests outstanding |
| running_o | output | 1 | Timer is counting |
| cancel_o | output | 1 | One-cycle timeout pulse |
| underflow_o | output | 1 | Sticky: a dequeue arrived with nothing outstanding |

## Verification
A wrong count shows at `count_o` on the very next cycle. A wrong arm, reload or stop decision shows at `running_o` at once when the timer state itself is wrong. When only the remaining value is wrong, the error stays hidden until the cancel pulse appears early, appears late, or never appears. That can take up to one full interval. For this reason the reload cases are checked by measuring the exact number of edges from the last arming event to the pulse, and not just by whether a pulse occurs. Random mixes of pulses, clears and short intervals exercise the boundary between reload and expiry in the same cycle.

// File: rtl/pw_pkg.sv
// Shared types for the outstanding-request watchdog.
// Assumes nothing beyond a standard SystemVerilog compiler.
package pw_pkg;
    // Command from the count logic to the timer, one per cycle.
    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_LOAD = 2'd1,
        TMR_STOP = 2'd2
    } tmr_cmd_e;
endpackage

// File: rtl/pw_count.sv
// Counter of outstanding requests. It reports the events that concern
// the timer: arm (zero to one), keep (still pending after a dequeue)
// and drain (one to zero). It assumes enq_i and deq_i are one-cycle
// pulses, each meaning exactly one request.
module pw_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             enq_i,
    input  logic             deq_i,
    output logic [CNT_W-1:0] count_o,
    output logic             underflow_o,
    output logic             arm_o,
    output logic             keep_o,
    output logic             drain_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             uf_q;
    logic             is_zero, is_one, is_full, only_enq, only_deq, both;

    // Classify the current count and the input pattern.
    always_comb begin
        is_zero  = (cnt_q == '0);
        is_one   = (cnt_q == CNT_ONE);
        is_full  = (cnt_q == CNT_MAX);
        only_enq = enq_i && !deq_i && !clr_i;
        only_deq = deq_i && !enq_i && !clr_i;
        both     = enq_i && deq_i && !clr_i;
    end

    // Next count: saturating increment, guarded decrement.
    always_comb begin
        cnt_d = cnt_q;
        if (only_enq && !is_full)
            cnt_d = cnt_q + CNT_ONE;
        else if (only_deq && !is_zero)
            cnt_d = cnt_q - CNT_ONE;
    end

    // Timer events derived from the count transition.
    always_comb begin
        arm_o   = only_enq && is_zero;
        drain_o = only_deq && is_one;
        keep_o  = (both && !is_zero) || (only_deq && !is_zero && !is_one);
    end

    // Count register with synchronous reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // Sticky underflow flag: set by a dequeue alone at count zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            uf_q <= 1'b0;
        else if (only_deq && is_zero)
            uf_q <= 1'b1;
    end

    assign count_o     = cnt_q;
    assign underflow_o = uf_q;
endmodule

// File: rtl/pw_timer.sv
// Down-counting interval timer. LOAD starts it with ticks_i, STOP halts
// it, and IDLE lets it count. expire_o is high in the cycle in which
// the last tick elapses, only when no command is given. It assumes
// ticks_i is nonzero whenever LOAD is given.
module pw_timer
    import pw_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  tmr_cmd_e         cmd_i,
    input  logic [TMR_W-1:0] ticks_i,
    output logic             running_o,
    output logic             expire_o
);
    localparam logic [TMR_W-1:0] TICK_ONE = TMR_W'(1);

    logic             run_q;
    logic [TMR_W-1:0] rem_q;

    // Expiry: last tick elapses with no command in the way.
    always_comb begin
        expire_o = run_q && (rem_q == TICK_ONE) && (cmd_i == TMR_IDLE);
    end

    // Timer state update by command, then by counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            run_q <= 1'b0;
            rem_q <= '0;
        end else begin
            case (cmd_i)
                TMR_LOAD: begin
                    run_q <= 1'b1;
                    rem_q <= ticks_i;
                end
                TMR_STOP: begin
                    run_q <= 1'b0;
                    rem_q <= '0;
                end
                default: begin
                    if (expire_o) begin
                        run_q <= 1'b0;
                        rem_q <= '0;
                    end else if (run_q) begin
                        rem_q <= rem_q - TICK_ONE;
                    end
                end
            endcase
        end
    end

    assign running_o = run_q;
endmodule

// File: rtl/pending_watchdog.sv
// Watchdog over outstanding high-priority requests. It counts
// enqueue/dequeue pulses and arms a timer on the zero-to-one count.
// The timer reloads on dequeues that leave work pending and stops
// when the count drains. If it runs out while requests are pending,
// a one-cycle cancel pulse is emitted. A zero interval_i selects the
// default timeout derived from CLK_HZ and PERIOD_MS.
module pending_watchdog
    import pw_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int TMR_W     = 24,
    parameter int CLK_HZ    = 125_000_000,
    parameter int PERIOD_MS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_i,
    input  logic             deq_i,
    input  logic             clr_i,
    input  logic [TMR_W-1:0] interval_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             cancel_o,
    output logic             underflow_o
);
    localparam int               DEF_TICKS_I = (CLK_HZ / 1000) * PERIOD_MS;
    localparam logic [TMR_W-1:0] DEF_TICKS   = TMR_W'(DEF_TICKS_I);

    logic             arm, keep, drain, expire, run;
    logic [CNT_W-1:0] cnt;
    logic [TMR_W-1:0] ticks;
    tmr_cmd_e         cmd;
    logic             cancel_q;

    pw_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .enq_i       (enq_i),
        .deq_i       (deq_i),
        .count_o     (cnt),
        .underflow_o (underflow_o),
        .arm_o       (arm),
        .keep_o      (keep),
        .drain_o     (drain)
    );

    // Interval selection: zero means the parameter default.
    always_comb begin
        ticks = (interval_i == '0) ? DEF_TICKS : interval_i;
    end

    // Timer command: drain stops, arm starts, keep reloads only a live timer.
    always_comb begin
        if (drain)
            cmd = TMR_STOP;
        else if (arm || (keep && run))
            cmd = TMR_LOAD;
        else
            cmd = TMR_IDLE;
    end

    pw_timer #(.TMR_W(TMR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .cmd_i     (cmd),
        .ticks_i   (ticks),
        .running_o (run),
        .expire_o  (expire)
    );

    // Cancel pulse: registered expiry, only with requests pending.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cancel_q <= 1'b0;
        else
            cancel_q <= expire && (cnt != '0);
    end

    assign count_o   = cnt;
    assign running_o = run;
    assign cancel_o  = cancel_q;
endmodule

// File: rtl/pw_watchdog_chk.sv
// Port-level property checker for pending_watchdog, attached by bind.
module pw_watchdog_chk #(
    parameter int CNT_W = 8,
    parameter int TMR_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_i,
    input logic             deq_i,
    input logic             clr_i,
    input logic [TMR_W-1:0] interval_i,
    input logic [CNT_W-1:0] count_o,
    input logic             running_o,
    input logic             cancel_o,
    input logic             underflow_o
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

    logic unused_ivl;
    assign unused_ivl = ^interval_i;

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_i && !deq_i && !clr_i && count_o != CMAX) |=> (count_o == $past(count_o) + CONE));

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_i && !deq_i && !clr_i && count_o == '0) |=> running_o);

    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_i && !enq_i && !clr_i && count_o == CONE) |=> (!running_o && !cancel_o));

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> !running_o);

    p_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_i && deq_i && !clr_i) |=> (count_o == $past(count_o)));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && !clr_i) |=> underflow_o);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0 && !running_o && !underflow_o && !cancel_o));

    p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |=> !cancel_o);

    p_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> (count_o != '0));
endmodule

bind pending_watchdog pw_watchdog_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_i       (enq_i),
    .deq_i       (deq_i),
    .clr_i       (clr_i),
    .interval_i  (interval_i),
    .count_o     (count_o),
    .running_o   (running_o),
    .cancel_o    (cancel_o),
    .underflow_o (underflow_o)
);

// File: tb/tb_pending_watchdog.sv
`timescale 1ns/1ps
module tb_pending_watchdog;
    localparam int CNT_W = 4;
    localparam int TMR_W = 16;
    localparam int HZ    = 200_000;
    localparam int PMS   = 50;
    localparam int DEF   = (HZ / 1000) * PMS;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enq = 1'b0, deq = 1'b0, clr = 1'b0;
    logic [TMR_W-1:0] ivl = TMR_W'(8);
    logic [CNT_W-1:0] count;
    logic             running, cancel, underflow;

    int total = 0;
    int fails = 0;

    // reference model state
    int m_cnt = 0, m_rem = 0;
    bit m_run = 0, m_can = 0, m_uf = 0;

    always #4 clk = ~clk;

    pending_watchdog #(.CNT_W(CNT_W), .TMR_W(TMR_W), .CLK_HZ(HZ), .PERIOD_MS(PMS)) dut (
        .clk(clk), .rst_n(rst_n), .enq_i(enq), .deq_i(deq), .clr_i(clr),
        .interval_i(ivl), .count_o(count), .running_o(running),
        .cancel_o(cancel), .underflow_o(underflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model of one clock edge.
    task automatic model_step(input bit e, input bit d, input bit c);
        bit load, stop, exp_now;
        int len;
        len = (ivl == 0) ? DEF : int'(ivl);
        load = 0; stop = 0;
        if (!rst_n || c) begin
            m_cnt = 0; m_run = 0; m_rem = 0; m_uf = 0; m_can = 0;
            return;
        end
        exp_now = m_run && m_rem == 1;
        if (e && d) begin
            if (m_cnt != 0 && m_run) load = 1;
        end else if (e) begin
            if (m_cnt == 0) load = 1;
            if (m_cnt < MAXC) m_cnt++;
        end else if (d) begin
            if (m_cnt == 0) m_uf = 1;
            else begin
                m_cnt--;
                if (m_cnt == 0) stop = 1;
                else if (m_run) load = 1;
            end
        end
        m_can = 0;
        if (stop) begin m_run = 0; m_rem = 0; end
        else if (load) begin m_run = 1; m_rem = len; end
        else if (exp_now) begin m_run = 0; m_rem = 0; m_can = 1; end
        else if (m_run) m_rem--;
    endtask

    // One cycle: drive, clock, model, compare away from the edge.
    task automatic tick(input bit e, input bit d, input bit c);
        enq = e; deq = d; clr = c;
        @(posedge clk);
        model_step(e, d, c);
        @(negedge clk);
        chk("R1 count", int'(count), m_cnt);
        chk("R2 running", int'(running), int'(m_run));
        chk("R5 cancel", int'(cancel), int'(m_can));
        chk("R8 underflow", int'(underflow), int'(m_uf));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic until_cancel(input int lim, output int n);
        n = 0;
        do begin tick(0, 0, 0); n++; end while (!cancel && n < lim);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        tick(0, 0, 0); tick(0, 0, 0);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 count", int'(count), 0);
        chk("R10 flags", int'({running, cancel, underflow}), 0);

        // R5 basic expiry, interval 8
        ivl = 8;
        tick(1, 0, 0);
        until_cancel(50, n);
        chk("R5 edges to cancel", n, 8);
        chk("R5 count kept", int'(count), 1);
        tick(0, 0, 0);
        chk("R11 single pulse", int'(cancel), 0);

        // R8 underflow: drain then dequeue at zero
        tick(0, 1, 0);
        tick(0, 1, 0);
        chk("R8 underflow set", int'(underflow), 1);
        chk("R8 count stays zero", int'(count), 0);
        idle(3);
        chk("R8 sticky", int'(underflow), 1);
        tick(0, 0, 1);

        // R3 reload on dequeue leaving pending
        tick(1, 0, 0); tick(1, 0, 0); tick(1, 0, 0);
        idle(2);
        tick(0, 1, 0);
        until_cancel(50, n);
        chk("R3 reload full interval", n, 8);

        // R6 no rearm after expiry while pending
        tick(0, 1, 0);
        chk("R6 stopped after deq", int'(running), 0);
        tick(1, 0, 0);
        chk("R6 stopped after enq", int'(running), 0);
        idle(12);
        chk("R6 no second cancel", int'(cancel), 0);
        tick(0, 1, 0); tick(0, 1, 0);
        tick(1, 0, 0);
        chk("R6 rearm after zero", int'(running), 1);

        // R4 drain stops, no cancel
        idle(3);
        tick(0, 1, 0);
        chk("R4 stopped", int'(running), 0);
        n = 0;
        for (int i = 0; i < 12; i++) begin tick(0, 0, 0); n += int'(cancel); end
        chk("R4 no cancel", n, 0);

        // R7 simultaneous enqueue and dequeue
        tick(1, 1, 0);
        chk("R7 at zero count", int'(count), 0);
        chk("R7 at zero idle", int'(running), 0);
        tick(1, 0, 0);
        idle(3);
        tick(1, 1, 0);
        chk("R7 count unchanged", int'(count), 1);
        until_cancel(50, n);
        chk("R7 reload", n, 8);

        // R9 clear overrides
        tick(1, 0, 0);
        tick(1, 1, 1);
        chk("R9 count", int'(count), 0);
        chk("R9 flags", int'({running, cancel, underflow}), 0);

        // R1 saturation
        for (int i = 0; i < MAXC + 5; i++) tick(1, 0, 0);
        chk("R1 saturated", int'(count), MAXC);
        tick(0, 0, 1);

        // R2 default interval when interval_i is zero
        ivl = '0;
        tick(1, 0, 0);
        until_cancel(DEF + 100, n);
        chk("R2 default interval", n, DEF);
        tick(0, 0, 1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit e, d, c;
            r = $urandom_range(0, 99);
            if (i % 97 == 0) ivl = TMR_W'($urandom_range(1, 9));
            e = (r < 30); d = (r >= 20 && r < 50); c = (r == 99);
            tick(e, d, c);
            if (cancel) chk("R11 pending at cancel", int'(count != 0), 1);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule